// File: doc/BRIEF.md
# Display List Pointer Counter

This block holds the 16-bit pointer that a video fetch engine walks through memory while reading its display list. Each fetch request puts the current pointer on the fetch address output and advances the pointer by one. A jump is done by fetching the two operand bytes and then reloading the pointer from them, one byte per cycle. The pointer bytes are never taken from the memory bus directly. They come from an internal byte latch that holds what the bus carried in the previous cycle. A load therefore runs one cycle behind the fetch that brought its byte in.

The clock's rising edge starts the first phase of a cycle and its falling edge starts the second. The pointer and the data latch update on the rising edge. The fetch address and its valid flag are latched on the falling edge, so they follow the internal pointer by half a cycle. A host processor can write either pointer byte. That write overrides every internal strobe in the same cycle.

Top module: `dlp_counter`

## Requirements
- R1: While rst_ni is low, ptr_o, addr_o and fetch_valid_o are all zero.
- R2: In a cycle with fetch_req_i high and no load or host write, addr_o shows the pointer value held at the start of that cycle from the falling edge onward and fetch_valid_o is high. The pointer reads one higher from the next cycle.
- R3: The increment carries across the whole 16 bits: $40FF becomes $4100 and $FFFF wraps to $0000.
- R4: load_lo_i replaces pointer bits 7:0 with the byte mem_data_i carried in the previous cycle, not the byte it carries in the current cycle.
- R5: When load_lo_i and fetch_req_i are both high, the low byte is loaded and no increment happens. addr_o still shows the pointer value from before the load, with fetch_valid_o high.
- R6: load_hi_i replaces pointer bits 15:8 with the previous cycle's mem_data_i byte. It leaves bits 7:0 unchanged and suppresses any increment in that cycle.
- R7: A jump runs as follows. From $4000, an opcode fetch gives $4001. A low-operand fetch with $20 on the bus gives $4002. A high-operand fetch with $60 on the bus, combined with load_lo_i, gives $4020. A load_hi_i in the next cycle gives $6020.
- R8: mem_data_i is captured only at the end of a cycle. A value present only in the first half of a cycle never reaches the pointer.
- R9: addr_o and fetch_valid_o change only on the falling clock edge. In a cycle without a fetch, fetch_valid_o is low and addr_o keeps its last value.
- R10: cpu_we_i bit 0 writes cpu_data_i into pointer bits 7:0, and bit 1 writes it into bits 15:8. In a cycle with any write bit set, fetch_req_i, load_lo_i and load_hi_i have no effect: there is no increment, no bus load, fetch_valid_o is low and addr_o holds.
- R11: In a cycle with no strobe and no write, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. The rising edge starts phase 1 and the falling edge starts phase 2. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Fetch request: output the pointer and increment it |
| load_lo_i | input | 1 | Load the pointer low byte from the data latch |
| load_hi_i | input | 1 | Load the pointer high byte from the data latch |
| cpu_we_i | input | 2 | Host write enables, one per pointer byte (bit 0 is the low byte) |
| cpu_data_i | input | 8 | Host write data |
| mem_data_i | input | 8 | Memory data bus, captured at the end of every cycle |
| ptr_o | output | 16 | Internal pointer |
| addr_o | output | 16 | Fetch address, latched on the falling edge |
| fetch_valid_o | output | 1 | High for a cycle in which a fetch was issued, latched on the falling edge |

## Verification
Fetch results (addr_o and fetch_valid_o) are due half a cycle after the inputs are applied, at the falling edge of the same cycle. Pointer updates become visible only after the next rising edge. A bus byte reaches the pointer only through a load in the cycle after the one in which it was driven. The bench drives inputs just after a rising edge and samples just before the next one. In that cycle it compares the fetch outputs with the item for that cycle, and it compares ptr_o with the pointer expected from the previous cycle's item. For the glitch case, the bench drives a wrong bus value early in the cycle and the right one after the falling edge, and then follows with a load.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  localparam int unsigned DLP_ADDR_W = 16;
  localparam int unsigned DLP_BYTE_W = 8;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_CPU  = 2'd2
  } lane_src_e;
endpackage

// File: rtl/dlp_data_latch.sv
module dlp_data_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // end-of-cycle capture: only the value settled by the rising edge counts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/dlp_op_arbiter.sv
module dlp_op_arbiter
  import dlp_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                        fetch_req_i,
  input  logic                        load_lo_i,
  input  logic                        load_hi_i,
  input  logic [LANES-1:0]            cpu_we_i,
  output logic                        fetch_o,
  output logic                        inc_o,
  output lane_src_e [LANES-1:0]       lane_src_o
);
  logic cpu_any;
  assign cpu_any = |cpu_we_i;
  assign fetch_o = fetch_req_i & ~cpu_any;
  // any byte load overrides the post-increment
  assign inc_o   = fetch_o & ~load_lo_i & ~load_hi_i;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic bus_ld;
    if (i == 0) begin : g_lo
      assign bus_ld = load_lo_i;
    end else if (i == LANES-1) begin : g_hi
      assign bus_ld = load_hi_i;
    end else begin : g_mid
      assign bus_ld = 1'b0;
    end

    always_comb begin
      if (cpu_any)     lane_src_o[i] = cpu_we_i[i] ? SRC_CPU : SRC_KEEP;
      else if (bus_ld) lane_src_o[i] = SRC_BUS;
      else             lane_src_o[i] = SRC_KEEP;
    end
  end
endmodule

// File: rtl/dlp_ptr_reg.sv
module dlp_ptr_reg
  import dlp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LANES = ADDR_W / BYTE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inc_i,
  input  lane_src_e [LANES-1:0] lane_src_i,
  input  logic [BYTE_W-1:0]     cpu_data_i,
  input  logic [BYTE_W-1:0]     bus_byte_i,
  output logic [ADDR_W-1:0]     ptr_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] nxt;

  assign base = inc_i ? ptr_o + ADDR_W'(1) : ptr_o;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (lane_src_i[i])
        SRC_BUS: nxt[i*BYTE_W +: BYTE_W] = bus_byte_i;
        SRC_CPU: nxt[i*BYTE_W +: BYTE_W] = cpu_data_i;
        default: nxt[i*BYTE_W +: BYTE_W] = base[i*BYTE_W +: BYTE_W];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else         ptr_o <= nxt;
  end
endmodule

// File: rtl/dlp_addr_latch.sv
module dlp_addr_latch #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] ptr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  // phase-2 output stage: external address trails the pointer by half a cycle
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= fetch_i;
      if (fetch_i) addr_o <= ptr_i;
    end
  end
endmodule

// File: rtl/dlp_counter.sv
module dlp_counter
  import dlp_pkg::*;
#(
  parameter int unsigned ADDR_W = DLP_ADDR_W,
  parameter int unsigned BYTE_W = DLP_BYTE_W,
  localparam int unsigned LANES = ADDR_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic              load_lo_i,
  input  logic              load_hi_i,
  input  logic [LANES-1:0]  cpu_we_i,
  input  logic [BYTE_W-1:0] cpu_data_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_valid_o
);
  logic [BYTE_W-1:0]     bus_byte;
  logic                  fetch;
  logic                  inc;
  lane_src_e [LANES-1:0] lane_src;

  dlp_data_latch #(.W(BYTE_W)) u_data_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mem_data_i),
    .q_o    (bus_byte)
  );

  dlp_op_arbiter #(.LANES(LANES)) u_arbiter (
    .fetch_req_i (fetch_req_i),
    .load_lo_i   (load_lo_i),
    .load_hi_i   (load_hi_i),
    .cpu_we_i    (cpu_we_i),
    .fetch_o     (fetch),
    .inc_o       (inc),
    .lane_src_o  (lane_src)
  );

  dlp_ptr_reg #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .lane_src_i (lane_src),
    .cpu_data_i (cpu_data_i),
    .bus_byte_i (bus_byte),
    .ptr_o      (ptr_o)
  );

  dlp_addr_latch #(.ADDR_W(ADDR_W)) u_addr_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fetch_i (fetch),
    .ptr_i   (ptr_o),
    .addr_o  (addr_o),
    .valid_o (fetch_valid_o)
  );
endmodule

// File: rtl/dlp_counter_chk.sv
module dlp_counter_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LANES = ADDR_W / BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_req_i,
  input logic              load_lo_i,
  input logic              load_hi_i,
  input logic [LANES-1:0]  cpu_we_i,
  input logic [BYTE_W-1:0] cpu_data_i,
  input logic [BYTE_W-1:0] mem_data_i,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              fetch_valid_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       age <= 2'd0;
    else if (age != 3) age <= age + 2'd1;
  end

  logic quiet;
  assign quiet = (cpu_we_i == '0);

  assert_fetch_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !load_lo_i && !load_hi_i && quiet) |=> ptr_o == $past(ptr_o) + ADDR_W'(1));

  assert_addr_tracks_ptr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> addr_o == ptr_o);

  assert_load_lo_prev_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2 && load_lo_i && quiet) |=> ptr_o[BYTE_W-1:0] == $past(mem_data_i, 2));

  assert_load_hi_prev_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2 && load_hi_i && !load_lo_i && quiet) |=>
      (ptr_o[ADDR_W-1 -: BYTE_W] == $past(mem_data_i, 2) &&
       ptr_o[BYTE_W-1:0] == $past(ptr_o[BYTE_W-1:0])));

  assert_cpu_lo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i[0] |=> ptr_o[BYTE_W-1:0] == $past(cpu_data_i));

  assert_cpu_blocks_fetch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i != '0) |-> !fetch_valid_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_req_i && !load_lo_i && !load_hi_i && quiet) |=> $stable(ptr_o));
endmodule

bind dlp_counter dlp_counter_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_req_i   (fetch_req_i),
  .load_lo_i     (load_lo_i),
  .load_hi_i     (load_hi_i),
  .cpu_we_i      (cpu_we_i),
  .cpu_data_i    (cpu_data_i),
  .mem_data_i    (mem_data_i),
  .ptr_o         (ptr_o),
  .addr_o        (addr_o),
  .fetch_valid_o (fetch_valid_o)
);

// File: tb/dlp_counter_bench.sv
module dlp_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        fetch_req = 1'b0, load_lo = 1'b0, load_hi = 1'b0;
  logic [1:0]  cpu_we = 2'b00;
  logic [7:0]  cpu_data = 8'h00, mem_data = 8'h00;
  logic [15:0] ptr, addr;
  logic        fvalid;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dlp_counter u_dlp_counter (
    .clk_i (clk), .rst_ni (rst_n), .fetch_req_i (fetch_req), .load_lo_i (load_lo),
    .load_hi_i (load_hi), .cpu_we_i (cpu_we), .cpu_data_i (cpu_data),
    .mem_data_i (mem_data), .ptr_o (ptr), .addr_o (addr), .fetch_valid_o (fvalid)
  );

  typedef struct {
    string       tag;
    logic [15:0] exp_addr;
    logic        exp_valid;
    logic [15:0] exp_ptr;
  } item_t;

  item_t q[$];

  // bench model state, built from the requirements
  logic [15:0] m_ptr = 16'h0000;
  logic [15:0] m_addr = 16'h0000;
  logic [7:0]  m_dq = 8'h00;

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drv(string tag, bit f, bit ll, bit lh, bit [1:0] cw, logic [7:0] cd,
                     logic [7:0] md, bit glitch = 0);
    item_t it;
    @(posedge clk);
    #1;
    fetch_req = f; load_lo = ll; load_hi = lh; cpu_we = cw; cpu_data = cd;
    mem_data = glitch ? ~md : md;
    it.tag = tag;
    if (cw != 2'b00) begin
      it.exp_valid = 1'b0;
      it.exp_ptr = m_ptr;
      if (cw[0]) it.exp_ptr[7:0] = cd;
      if (cw[1]) it.exp_ptr[15:8] = cd;
    end else begin
      it.exp_valid = f;
      if (f) m_addr = m_ptr;
      it.exp_ptr = (f && !ll && !lh) ? m_ptr + 16'd1 : m_ptr;
      if (ll) it.exp_ptr[7:0] = m_dq;
      if (lh) it.exp_ptr[15:8] = m_dq;
    end
    it.exp_addr = m_addr;
    m_ptr = it.exp_ptr;
    m_dq = md;
    q.push_back(it);
    if (glitch) begin
      #5 mem_data = md;
    end
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) drv(tag, 0, 0, 0, 2'b00, 8'h00, 8'h00);
  endtask

  // monitor: fetch outputs due this cycle, pointer due from the previous cycle
  initial begin
    item_t prev;
    bit    have_prev = 0;
    forever begin
      @(posedge clk);
      #8;
      if (rst_n) begin
        if (have_prev) check(prev.tag, "ptr_o", ptr, prev.exp_ptr);
        have_prev = 0;
        if (q.size() > 0) begin
          prev = q.pop_front();
          have_prev = 1;
          check(prev.tag, "fetch_valid_o", 16'(fvalid), 16'(prev.exp_valid));
          check(prev.tag, "addr_o", addr, prev.exp_addr);
        end
      end
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #8;
    check("R1", "ptr_o in reset", ptr, 16'h0000);
    check("R1", "addr_o in reset", addr, 16'h0000);
    check("R1", "fetch_valid_o in reset", 16'(fvalid), 16'h0000);
    @(posedge clk);
    #2 rst_n = 1'b1;

    // R10: host writes set the start, and override strobes in the same cycle
    drv("R10", 0, 0, 0, 2'b01, 8'h00, 8'h11);
    drv("R10", 1, 1, 1, 2'b10, 8'h40, 8'h22);
    idle("R11", 2);

    // R7: jump example, R2 fetch, R5 load plus fetch, R6 high load
    drv("R7", 1, 0, 0, 2'b00, 8'h00, 8'h01);
    idle("R11", 2);
    drv("R7", 1, 0, 0, 2'b00, 8'h00, 8'h20);
    drv("R5", 1, 1, 0, 2'b00, 8'h00, 8'h60);
    drv("R6", 0, 0, 1, 2'b00, 8'h00, 8'hFF);
    drv("R7", 0, 0, 0, 2'b00, 8'h00, 8'h00);
    #7 check("R7", "pointer after jump", ptr, 16'h6020);
    check("R9", "addr_o holds after idle", addr, 16'h4002);

    // R2: back-to-back fetches
    drv("R2", 1, 0, 0, 2'b00, 8'h00, 8'h00);
    drv("R2", 1, 0, 0, 2'b00, 8'h00, 8'h00);
    drv("R2", 1, 0, 0, 2'b00, 8'h00, 8'h00);

    // R3: carry across the byte boundary and wrap
    drv("R3", 0, 0, 0, 2'b01, 8'hFF, 8'h00);
    drv("R3", 1, 0, 0, 2'b00, 8'h00, 8'h00);
    drv("R3", 0, 0, 0, 2'b00, 8'h00, 8'h00);
    #7 check("R3", "carry into high byte", ptr, 16'h6100);
    drv("R3", 0, 0, 0, 2'b11, 8'hFF, 8'h00);
    drv("R3", 1, 0, 0, 2'b00, 8'h00, 8'h00);
    drv("R3", 0, 0, 0, 2'b00, 8'h00, 8'h00);
    #7 check("R3", "wrap to zero", ptr, 16'h0000);

    // R4: low load takes the previous cycle's byte
    drv("R4", 0, 0, 0, 2'b00, 8'h00, 8'hAA);
    drv("R4", 0, 1, 0, 2'b00, 8'h00, 8'h55);
    drv("R4", 0, 0, 0, 2'b00, 8'h00, 8'h00);
    #7 check("R4", "low byte from previous bus", ptr, 16'h00AA);

    // R6: high load with fetch, low byte unchanged, no increment
    drv("R6", 0, 0, 0, 2'b00, 8'h00, 8'h3C);
    drv("R6", 1, 0, 1, 2'b00, 8'h00, 8'h99);

    // R8: bus value present only early in the cycle is not captured
    drv("R8", 0, 0, 0, 2'b00, 8'h00, 8'h5A, 1);
    drv("R8", 0, 1, 0, 2'b00, 8'h00, 8'h00);
    drv("R8", 0, 0, 0, 2'b00, 8'h00, 8'h00);
    #7 check("R8", "late bus byte loaded", ptr, 16'h3C5A);

    // R5 and R6 together, R10 blocking a fetch
    drv("R5", 0, 0, 0, 2'b00, 8'h00, 8'h77);
    drv("R5", 1, 1, 1, 2'b00, 8'h00, 8'h00);
    drv("R10", 1, 1, 0, 2'b01, 8'h12, 8'h00);
    drv("R9", 0, 0, 0, 2'b00, 8'h00, 8'h00);
    idle("R11", 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule